// File: doc/BRIEF.md
# Convergent Rounding Right Shifter

This block divides a signed two's-complement word by a power of two and rounds the quotient to the nearest integer. When the discarded part is exactly one half, it picks the even neighbour. The shift distance `shamt` selects the divisor 2^shamt. A zero distance passes the word through untouched. The result has the same width as the input and is never saturated.

The rounding increment is chosen from the bits of the input. The bits strictly below the half position are tested. If any of them is set, the increment is a plain half (2^(shamt-1)). If they are all clear, the increment is bit `shamt` of the input moved down one place. That makes an exact tie round up only when the truncated quotient is odd, and it leaves exact multiples unchanged. The input is sign-extended to twice its width before the increment is added, so the sum cannot wrap. The sum is then shifted arithmetically and its low half is returned.

A parameter chooses between a purely combinational path and a single output register with an asynchronous active-low reset.

Top module: `rnd_even_shr`

## Requirements
- R1: With `shamt` = 0, `dout` equals `din` bit for bit.
- R2: When the low `shamt` bits of `din` are all zero, `dout` is the exact quotient `din` / 2^shamt, sign preserved.
- R3: When the discarded fraction is below one half, the result is the quotient rounded toward minus infinity. When it is above one half, the result is one greater. In every case |`dout`·2^shamt − `din`| ≤ 2^(shamt−1).
- R4: When the discarded fraction is exactly one half, the result is the even one of the two neighbours (bit 0 of `dout` is 0), for positive and negative inputs alike.
- R5: Negative inputs follow the same nearest/ties-to-even rule on the signed value (for example −10 with `shamt` = 2 gives −2, and −1 with `shamt` = 1 gives 0). A non-negative input never produces a negative result.
- R6: The increment never overflows at the extremes: 0x7FFFFFFF with `shamt` = 1 gives 0x40000000, and with `shamt` = 31 it gives 1. 0x80000000 and 0xBFFFFFFF with `shamt` = 31 both give 0xFFFFFFFF.
- R7: With `OUT_REG` = 0, `dout` follows the inputs in the same cycle. With `OUT_REG` = 1, `dout` shows the result of the inputs present at the previous rising edge of `clk` and reads 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| din | input | DATA_W (32) | Signed dividend |
| shamt | input | SHIFT_W (5) | Shift distance, 0 to DATA_W−1 |
| dout | output | DATA_W (32) | Rounded signed quotient |

## Verification
The bench builds two instances at the default width of 32 bits. One uses `OUT_REG` = 0 and the other `OUT_REG` = 1. The combinational one is checked in the cycle the inputs change, and the registered one one edge later and during reset, which brings the latency and reset behaviour of R7 within reach. The 32-bit width lets `shamt` reach 31, where a one-half increment added to 0x7FFFFFFF would wrap a 32-bit sum. Exact ties of both parities and both signs are therefore exercised at the top of the range as well as at small distances.

// File: rtl/rnd_even_shr_pkg.sv
package rnd_even_shr_pkg;
   parameter int unsigned RES_DEF_W = 32;

   function automatic int unsigned res_shift_w(input int unsigned w);
      return $clog2(w);
   endfunction
endpackage

// File: rtl/res_incr.sv
module res_incr #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SHIFT_W = 5
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHIFT_W-1:0] shamt,
   output logic [DATA_W-1:0]  incr
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] half_bit;
   logic [DATA_W-1:0] below_mask;
   logic [DATA_W-1:0] lsb_bit;
   logic              below_zero;

   always_comb begin
      half_bit   = '0;
      below_mask = '0;
      lsb_bit    = ONE << shamt;
      if (shamt != '0) begin
         half_bit   = ONE << (shamt - SHIFT_W'(1));
         below_mask = half_bit - ONE;
      end
      below_zero = ((din & below_mask) == '0);
   end

   always_comb begin
      if (shamt == '0)
         incr = '0;
      else if (below_zero)
         incr = (din & lsb_bit) >> 1;
      else
         incr = half_bit;
   end
endmodule

// File: rtl/res_shift.sv
module res_shift #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SHIFT_W = 5
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHIFT_W-1:0] shamt,
   input  logic [DATA_W-1:0]  incr,
   output logic [DATA_W-1:0]  dout
);
   localparam int unsigned WIDE_W = 2 * DATA_W;

   logic signed [WIDE_W-1:0] wide_sum;

   always_comb begin
      wide_sum = $signed({{DATA_W{din[DATA_W-1]}}, din}) +
                 $signed({{DATA_W{1'b0}}, incr});
   end

   assign dout = DATA_W'(wide_sum >>> shamt);
endmodule

// File: rtl/rnd_even_shr.sv
module rnd_even_shr
   import rnd_even_shr_pkg::*;
#(
   parameter int unsigned DATA_W  = RES_DEF_W,
   parameter int unsigned SHIFT_W = res_shift_w(DATA_W),
   parameter bit          OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  din,
   input  logic [SHIFT_W-1:0] shamt,
   output logic [DATA_W-1:0]  dout
);
   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0)
         $error("rnd_even_shr: DATA_W must be a power of two of at least 2");
      if (SHIFT_W != $clog2(DATA_W))
         $error("rnd_even_shr: SHIFT_W must equal clog2(DATA_W)");
   endgenerate

   logic [DATA_W-1:0] incr;
   logic [DATA_W-1:0] rnd_q;

   res_incr #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_incr (
      .din   (din),
      .shamt (shamt),
      .incr  (incr)
   );

   res_shift #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_shift (
      .din   (din),
      .shamt (shamt),
      .incr  (incr),
      .dout  (rnd_q)
   );

   generate
      if (OUT_REG) begin : g_reg
         logic [DATA_W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= rnd_q;
         end
         assign dout = q_r;
      end else begin : g_comb
         assign dout = rnd_q;
      end
   endgenerate
endmodule

// File: rtl/rnd_even_shr_chk.sv
module rnd_even_shr_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SHIFT_W = 5,
   parameter bit          OUT_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [DATA_W-1:0]  din,
   input logic [SHIFT_W-1:0] shamt,
   input logic [DATA_W-1:0]  dout
);
   localparam int unsigned EW = 2 * DATA_W + 2;

   logic [DATA_W-1:0]  o_din;
   logic [SHIFT_W-1:0] o_n;
   logic               o_vld;

   generate
      if (OUT_REG) begin : g_hist
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_vld <= 1'b0;
               o_din <= '0;
               o_n   <= '0;
            end else begin
               o_vld <= 1'b1;
               o_din <= din;
               o_n   <= shamt;
            end
         end
      end else begin : g_now
         assign o_vld = 1'b1;
         assign o_din = din;
         assign o_n   = shamt;
      end
   endgenerate

   logic signed [EW-1:0] err;
   logic        [EW-1:0] err_abs;
   logic        [EW-1:0] half;
   logic [DATA_W-1:0]    low_mask;
   logic [DATA_W-1:0]    half_w;
   logic                 tie;

   always_comb begin
      err = ($signed({{(DATA_W+2){dout[DATA_W-1]}}, dout}) <<< o_n) -
            $signed({{(DATA_W+2){o_din[DATA_W-1]}}, o_din});
      err_abs  = err[EW-1] ? EW'(-err) : EW'(err);
      half     = (o_n == '0) ? '0 : (EW'(1) << (o_n - SHIFT_W'(1)));
      low_mask = (DATA_W'(1) << o_n) - DATA_W'(1);
      half_w   = half[DATA_W-1:0];
      tie      = (o_n != '0) && ((o_din & low_mask) == half_w);
   end

   AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && o_n == '0) |-> dout == o_din); // R1

   AST_EXACT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && o_n != '0 && (o_din & low_mask) == '0) |->
         dout == DATA_W'($signed(o_din) >>> o_n)); // R2

   AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      o_vld |-> err_abs <= half); // R3

   AST_TIE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && tie) |-> !dout[0]); // R4

   AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && !o_din[DATA_W-1]) |-> !dout[DATA_W-1]); // R5
endmodule

bind rnd_even_shr rnd_even_shr_chk #(
   .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .din(din), .shamt(shamt), .dout(dout)
);

// File: tb/test_rnd_even_shr.sv
module test_rnd_even_shr;
   localparam int W = 32;
   localparam int NV = 17;

   localparam logic [31:0] VA [NV] = '{
      32'h12345678, 32'd100, 32'd101, 32'd103, 32'd10, 32'd14,
      32'hFFFFFFF6, 32'hFFFFFFF2, 32'hFFFFFFF3, 32'h7FFFFFFF, 32'h7FFFFFFF,
      32'h80000000, 32'h40000000, 32'hC0000000, 32'hBFFFFFFF, 32'd3,
      32'hFFFFFFFF};
   localparam int VN [NV] = '{0, 2, 2, 2, 2, 2, 2, 2, 2, 1, 31, 31, 31, 31, 31, 1, 1};
   localparam logic [31:0] VE [NV] = '{
      32'h12345678, 32'd25, 32'd25, 32'd26, 32'd2, 32'd4,
      32'hFFFFFFFE, 32'hFFFFFFFC, 32'hFFFFFFFD, 32'h40000000, 32'd1,
      32'hFFFFFFFF, 32'd0, 32'd0, 32'hFFFFFFFF, 32'd2,
      32'd0};
   localparam string VR [NV] = '{
      "R1", "R2", "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R6", "R6",
      "R6", "R4", "R4", "R6", "R4", "R5"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  din = '0;
   logic [4:0]    shamt = '0;
   logic [W-1:0]  dout_c;
   logic [W-1:0]  dout_r;
   int            total = 0;
   int            bad = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   rnd_even_shr #(.OUT_REG(1'b0)) i_rnd_even_shr (
      .clk(clk), .rst_n(rst_n), .din(din), .shamt(shamt), .dout(dout_c));

   rnd_even_shr #(.OUT_REG(1'b1)) i_rnd_even_shr_reg (
      .clk(clk), .rst_n(rst_n), .din(din), .shamt(shamt), .dout(dout_r));

   function automatic logic [31:0] ref_round(input logic [31:0] a, input int n);
      longint sa, p, q, r, h;
      sa = longint'($signed(a));
      if (n == 0) return a;
      p = longint'(1) <<< n;
      q = sa >>> n;
      r = sa - q * p;
      h = p / 2;
      if (r > h || (r == h && q[0])) q = q + 1;
      return q[31:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic [31:0] a, input int n,
                        input logic [31:0] e);
      @(negedge clk);
      din   = a;
      shamt = n[4:0];
      #1;
      check(req, dout_c, e);
      @(negedge clk);
      check("R7", dout_r, e);
   endtask

   initial begin
      logic [31:0] lfsr;
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      din = 32'h7FFFFFFF;
      shamt = 5'd1;
      repeat (3) @(negedge clk);
      check("R7", dout_r, 32'd0);          // R7 reset state
      check("R6", dout_c, 32'h40000000);   // comb path live in reset
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) apply(VR[i], VA[i], VN[i], VE[i]);

      // R1 pass-through of the most negative value
      apply("R1", 32'h80000000, 0, 32'h80000000);
      // R2 exact multiple, negative
      apply("R2", 32'hFFFFF000, 12, 32'hFFFFFFFF);
      // R7 same-cycle response of the combinational build
      @(negedge clk);
      din = 32'd6; shamt = 5'd2;
      #1 check("R7", dout_c, 32'd2);
      din = 32'd7;
      #1 check("R7", dout_c, 32'd2);

      lfsr = 32'hACE1_2468;
      for (int k = 0; k < 400; k++) begin
         int n;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         n = k % 32;
         apply("R3", lfsr, n, ref_round(lfsr, n));
      end
      for (int n = 1; n < 32; n++) begin
         logic [31:0] t;
         t = (32'd1 << (n - 1)) | (32'd1 << n);   // R4 odd tie, rounds up
         apply("R4", t, n, ref_round(t, n));
         t = -t;                                  // R4 negative tie
         apply("R4", t, n, ref_round(t, n));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule